// File: doc/BRIEF.md
# DMA Interrupt and Channel-Start Controller

This block holds the shared control state of a seven-channel DMA engine. It has a priority/enable word, with one enable bit per channel, and an interrupt word. The interrupt word combines writable enable fields, sticky completion flags that software clears by writing a one, a force bit, a global enable and a sticky "interrupt already sent" bit. The block also watches writes to each channel's control word and fires a one-cycle start pulse toward that channel's data mover when the start conditions hold.

Completion pulses from the data movers set the per-channel flags. The block drives a single-cycle request to the system interrupt controller only when the interrupt condition newly becomes true while the sent bit is clear. Slot 5 of the seven is not used: its control word can be stored, but it never starts and its completion input is ignored. All register accesses go through one 32-bit write/read port using byte offsets.

Top module: `dmac_ctrl_core`

## Requirements
- R1: The channel-enable word at offset 0xF0 is fully writable and reads back as written; it resets to 0.
- R2: A write to the interrupt word at offset 0xF4 loads bits 0-5, 15 and 16-23 from the written value; the other bits of 0-23 always read 0.
- R3: Flag bits 24..30 are write-1-to-clear: a one clears the flag, a zero leaves it unchanged, and a write never sets a flag.
- R4: A completion pulse on channel n sets flag bit 24+n only when enable bit 16+n is set; completion on channel 5 has no effect.
- R5: After every interrupt-word write or completion, bit 31 equals the interrupt condition: (bit 23 set and any of bits 24..30 set) or bit 15 set.
- R6: irq_pulse is high for one cycle, in the cycle after the update, when the condition is true and bit 31 was clear before the update; no pulse is produced while bit 31 stays set.
- R7: A write to channel n's control word at offset 0x80+0x10*n+0x8 pulses start_pulse[n] in the following cycle only when data bit 24 is set, enable-word bit 3+4*n is set, and n is not 5.
- R8: A channel control word reads back as written, except that bit 24 is cleared by a completion pulse of that channel.
- R9: reg_rdata shows the word at reg_addr one cycle later; unmapped offsets read 0.
- R10: When an interrupt-word write and a completion happen in the same cycle, the write is applied first and the completion flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| done_pulse | input | NCH | Per-channel completion pulses |
| start_pulse | output | NCH | Per-channel start pulses |
| irq_pulse | output | 1 | Request to the interrupt controller |

## Verification
The assertions check on every cycle that the sent bit matches the interrupt condition held in the stored word. They also check that an interrupt request only accompanies a 0-to-1 change of the sent bit and never appears twice in a row, and that every start pulse follows a write with the matching channel enable set. The bench scenarios are the only place to show the field masking and write-1-to-clear results, the gating of completions by their enables, the control-word bit-24 clearing, the same-cycle write-plus-completion ordering, and re-arming after flags are cleared. They also cover the full sweep of channel, enable bit and start bit for the start decision.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam logic [7:0] OFS_PCR = 8'hF0;
  localparam logic [7:0] OFS_ICR = 8'hF4;
  localparam logic [7:0] OFS_CH_BASE = 8'h80;
  localparam logic [3:0] OFS_CHCR_LO = 4'h8;
  localparam logic [31:0] ICR_WR_MASK = 32'h00FF_803F;
  localparam logic [31:0] ICR_FLAG_MASK = 32'h7F00_0000;
  localparam int ICR_FORCE_BIT = 15;
  localparam int ICR_GLOBAL_BIT = 23;
  localparam int ICR_SENT_BIT = 31;
  localparam int ICR_EN_LSB = 16;
  localparam int ICR_FLAG_LSB = 24;
  localparam int CHCR_GO_BIT = 24;
  localparam int UNUSED_CH = 5;
endpackage

// File: rtl/dmac_icr_unit.sv
module dmac_icr_unit import dmac_pkg::*; #(
  parameter int NCH = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           icr_wr,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] done_v,
  output logic [31:0]    icr_q,
  output logic           irq_q
);
  logic [31:0] base, nxt;
  logic        cond;

  always_comb begin
    if (icr_wr)
      base = (wdata & ICR_WR_MASK) | (icr_q & ~wdata & ICR_FLAG_MASK);
    else
      base = icr_q & ~(32'h1 << ICR_SENT_BIT);
    nxt = base;
    for (int n = 0; n < NCH; n++) begin
      if (done_v[n] && base[ICR_EN_LSB + n])
        nxt[ICR_FLAG_LSB + n] = 1'b1;
    end
    cond = (nxt[ICR_GLOBAL_BIT] && |(nxt & ICR_FLAG_MASK)) || nxt[ICR_FORCE_BIT];
    nxt[ICR_SENT_BIT] = cond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      icr_q <= nxt;
      irq_q <= cond && !icr_q[ICR_SENT_BIT];
    end
  end
endmodule

// File: rtl/dmac_chan_ctl.sv
module dmac_chan_ctl import dmac_pkg::*; #(
  parameter bit USED = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        chcr_wr,
  input  logic [31:0] wdata,
  input  logic        chan_en,
  input  logic        done,
  output logic [31:0] chcr_q,
  output logic        start_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chcr_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (chcr_wr) begin
        chcr_q  <= wdata;
        start_q <= USED && wdata[CHCR_GO_BIT] && chan_en;
      end else if (done && USED) begin
        chcr_q[CHCR_GO_BIT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmac_ctrl_core.sv
module dmac_ctrl_core import dmac_pkg::*; #(
  parameter int NCH    = 7,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    done_pulse,
  output logic [NCH-1:0]    start_pulse,
  output logic              irq_pulse
);
  localparam logic [NCH-1:0] USED_MASK = ~(NCH'(1) << UNUSED_CH);

  logic [31:0] pcr_q, icr_q, rd_val;
  logic [31:0] chcr_arr [NCH];
  logic        hit_pcr, hit_icr;
  logic [NCH-1:0] hit_ch;

  assign hit_pcr = (reg_addr == ADDR_W'(OFS_PCR));
  assign hit_icr = (reg_addr == ADDR_W'(OFS_ICR));

  always_ff @(posedge clk) begin
    if (rst) pcr_q <= '0;
    else if (reg_wr && hit_pcr) pcr_q <= reg_wdata;
  end

  dmac_icr_unit #(.NCH(NCH)) u_icr (
    .clk(clk), .rst(rst), .icr_wr(reg_wr && hit_icr), .wdata(reg_wdata),
    .done_v(done_pulse & USED_MASK), .icr_q(icr_q), .irq_q(irq_pulse)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign hit_ch[n] = (reg_addr == ADDR_W'(OFS_CH_BASE + 8'(16 * n) + 8'(OFS_CHCR_LO)));
    dmac_chan_ctl #(.USED(n != UNUSED_CH)) u_ch (
      .clk(clk), .rst(rst), .chcr_wr(reg_wr && hit_ch[n]), .wdata(reg_wdata),
      .chan_en(pcr_q[3 + 4 * n]), .done(done_pulse[n]),
      .chcr_q(chcr_arr[n]), .start_q(start_pulse[n])
    );
  end

  always_comb begin
    rd_val = '0;
    if (hit_pcr) rd_val = pcr_q;
    if (hit_icr) rd_val = icr_q;
    for (int n = 0; n < NCH; n++)
      if (hit_ch[n]) rd_val = chcr_arr[n];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_val;
  end
endmodule

// File: rtl/dmac_ctrl_chk.sv
module dmac_ctrl_chk #(
  parameter int NCH = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic [NCH-1:0] start_pulse,
  input logic           irq_pulse,
  input logic [31:0]    icr_q,
  input logic [31:0]    pcr_q
);
  // R5: sent bit mirrors the stored interrupt condition
  p_sent_tracks_cond_r5: assert property (@(posedge clk) disable iff (rst)
    icr_q[31] == ((icr_q[23] && |icr_q[30:24]) || icr_q[15]));

  // R6: request only on a rising sent bit
  p_irq_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (icr_q[31] && !$past(icr_q[31])));

  // R6: never two requests back to back
  p_irq_gap_r6: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R7: a start follows a register write
  p_start_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (|start_pulse) |-> $past(reg_wr));

  for (genvar n = 0; n < NCH; n++) begin : g_en
    // R7: a start needs the channel enable
    p_start_enabled_r7: assert property (@(posedge clk) disable iff (rst)
      start_pulse[n] |-> $past(pcr_q[3 + 4 * n]));
  end
endmodule

bind dmac_ctrl_core dmac_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .start_pulse(start_pulse),
  .irq_pulse(irq_pulse), .icr_q(icr_q), .pcr_q(pcr_q)
);

// File: tb/dmac_ctrl_core_test.sv
module dmac_ctrl_core_test;
  localparam int NCH = 7;
  logic clk = 0, rst = 1, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NCH-1:0] done_pulse = 0, start_pulse;
  logic irq_pulse;
  int checks = 0, errors = 0;
  logic [NCH-1:0] s_start;
  logic s_irq;
  logic [31:0] rv;

  always #10 clk = ~clk;

  dmac_ctrl_core #(.NCH(NCH), .ADDR_W(8)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [NCH-1:0] dn);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; done_pulse = dn;
    @(negedge clk); s_start = start_pulse; s_irq = irq_pulse;
    reg_wr = 0; done_pulse = 0;
  endtask

  task automatic pulse_done(input logic [NCH-1:0] dn);
    @(negedge clk); done_pulse = dn; reg_addr = 8'h00;
    @(negedge clk); s_start = start_pulse; s_irq = irq_pulse; done_pulse = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_wr = 0; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset start", 32'(start_pulse), 0);
    chk("R6 reset irq", 32'(irq_pulse), 0);
    rd(8'hF0, rv); chk("R1 reset pcr", rv, 0);
    rd(8'hF4, rv); chk("R2 reset icr", rv, 0);
    wr(8'hF0, 32'hA5C3_1E77, 0);
    rd(8'hF0, rv); chk("R1 pcr readback", rv, 32'hA5C3_1E77);
    // R2: mask, force bit raises condition
    wr(8'hF4, 32'hFFFF_FFFF, 0);
    chk("R6 irq on force", 32'(s_irq), 1);
    rd(8'hF4, rv); chk("R2 icr mask", rv, 32'h80FF_803F);
    wr(8'hF4, 32'h7F00_0000, 0);
    chk("R6 no irq after clear", 32'(s_irq), 0);
    rd(8'hF4, rv); chk("R5 sent cleared", rv, 0);
    // R7: exhaustive start sweep
    for (int n = 0; n < NCH; n++)
      for (int en = 0; en < 2; en++)
        for (int go = 0; go < 2; go++) begin
          logic [NCH-1:0] exp;
          wr(8'hF0, 32'(en) << (3 + 4 * n), 0);
          wr(8'(8'h80 + 16 * n + 8), (32'(go) << 24) | 32'(n), 0);
          exp = (en == 1 && go == 1 && n != 5) ? (NCH'(1) << n) : '0;
          chk($sformatf("R7 start ch%0d en%0d go%0d", n, en, go), 32'(s_start), 32'(exp));
          rd(8'(8'h80 + 16 * n + 8), rv);
          chk("R8 chcr readback", rv, (32'(go) << 24) | 32'(n));
        end
    // R4: completion gating sweep (global off, no irq)
    for (int n = 0; n < NCH; n++)
      for (int en = 0; en < 2; en++) begin
        wr(8'hF4, 32'h7F00_0000 | (32'(en) << (16 + n)), 0);
        pulse_done(NCH'(1) << n);
        chk("R4 no irq w/o global", 32'(s_irq), 0);
        rd(8'hF4, rv);
        chk($sformatf("R4 flag ch%0d en%0d", n, en), rv,
            (32'(en) << (16 + n)) | ((en == 1 && n != 5) ? (32'h1 << (24 + n)) : 0));
      end
    // R5/R6 edge and re-arm
    wr(8'hF4, 32'h7F81_0000, 0);
    rd(8'hF4, rv); chk("R3 clear all flags", rv, 32'h0081_0000);
    pulse_done(7'h01); chk("R6 irq on completion", 32'(s_irq), 1);
    rd(8'hF4, rv); chk("R5 sent set", rv, 32'h8181_0000);
    pulse_done(7'h01); chk("R6 no repeat irq", 32'(s_irq), 0);
    wr(8'hF4, 32'h0181_0000, 0); chk("R6 no irq on clear", 32'(s_irq), 0);
    rd(8'hF4, rv); chk("R3 w1c flag", rv, 32'h0081_0000);
    pulse_done(7'h01); chk("R6 re-armed irq", 32'(s_irq), 1);
    wr(8'hF4, 32'h0000_8000, 0); chk("R6 force while sent", 32'(s_irq), 0);
    rd(8'hF4, rv); chk("R3 zero keeps flag", rv, 32'h8100_8000);
    wr(8'hF4, 32'h0, 0);
    rd(8'hF4, rv); chk("R5 cond false", rv, 32'h0100_0000);
    // R10: same-cycle write and completion
    wr(8'hF4, 32'h7F81_0000, 7'h01);
    chk("R10 irq", 32'(s_irq), 1);
    rd(8'hF4, rv); chk("R10 order", rv, 32'h8181_0000);
    // R8: completion clears go bit
    wr(8'hF0, 32'h0000_0800, 0);
    wr(8'hA8, 32'h0100_0201, 0);
    chk("R7 ch2 start", 32'(s_start), 32'h04);
    pulse_done(7'h04);
    rd(8'hA8, rv); chk("R8 go cleared", rv, 32'h0000_0201);
    rd(8'h84, rv); chk("R9 unmapped", rv, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule